// File: doc/BRIEF.md
# Multimode Instruction Operand Decoder

This block sits between an instruction fetch buffer and the execute stage of a byte-stream processor. Each cycle it looks at a window of up to six instruction bytes, starting at the opcode. From that window it works out the addressing mode of the one flexible operand, the pointer or register number, the immediate or offset value, the register operands that follow, and the total instruction length. The fetch unit uses the length to advance, and the execute stage uses the decoded fields. For relative jumps it also produces the branch target.

The flexible operand always begins at the byte right after the opcode. Its pointer byte has a double role: bit 0 is a mode modifier. In indirect mode it requests post-increment. In indexed mode it selects a two-byte offset instead of a one-byte offset. The register actually used is the byte with bit 0 cleared. This modifier changes the instruction length, so the length can only be known once the operand bytes have been decoded. All outputs are registered, one cycle after the window is presented.

Top module: `mm_operand_decoder`

## Requirements
- R1: The opcode class comes from opcode bits [7:5]: 010 is three-operand, 011 is two-operand, 100 is load, 101 is store. Opcode bit 4 set means byte size and clear means word size. Opcode bits [1:0] give the mode: 00 register, 01 immediate, 10 indirect, 11 indexed. Opcodes 0xE0 to 0xEF are relative jumps.
- R2: In register mode, `src_reg` equals byte 1 unchanged, and the flexible operand takes one byte.
- R3: In immediate mode, byte size takes one byte, zero-extended into `operand`. Word size takes two bytes, low byte first, and makes the instruction one byte longer.
- R4: In indirect mode, `post_inc` equals bit 0 of byte 1, and `src_reg` is byte 1 with bit 0 cleared.
- R5: In indexed mode, when byte 1 bit 0 is clear, a one-byte offset follows and is sign-extended to 16 bits. When it is set, a two-byte offset follows, low byte first, and `long_idx` is 1. In both cases `src_reg` has bit 0 cleared.
- R6: `length` is 1 (opcode) plus the flexible-operand bytes plus the trailing register bytes. Three-operand forms have 2 trailing register bytes; the other multimode classes have 1. Examples: a byte load is 3 bytes in register, immediate and indirect mode, 4 bytes short-indexed and 5 bytes long-indexed.
- R7: The final byte is `dst_reg`. In three-operand forms, the byte before it is reported on `aux_reg`.
- R8: In a store, the final byte is the data source, reported on `aux_reg`. `dst_reg` is 0 and `wr_dst` is 0. A store with immediate mode is illegal.
- R9: `wr_dst` is 1 only when the instruction writes a register and `dst_reg` is nonzero. Register 0 stays readable as zero, and writes to it are dropped.
- R10: A jump is 2 bytes long, and `jmp_target` equals `pc + 2 + sign-extended byte 1`, taken modulo 2^16.
- R11: `out_valid` rises one cycle after a window whose `win_cnt` is at least the computed length. When `win_cnt` is too small, `out_valid` is 0 and all fields are 0.
- R12: Any opcode outside the defined classes, or a store with immediate mode, gives `illegal` = 1 with `length` = 1.
- R13: While reset is held, `out_valid` and all fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win | input | 48 | Fetch window; byte i at bits [8i+7:8i], byte 0 is the opcode |
| win_cnt | input | 3 | Number of valid bytes in the window |
| pc | input | 16 | Address of the opcode byte |
| out_valid | output | 1 | Decoded instruction is complete |
| mode | output | 2 | Flexible-operand mode |
| src_reg | output | 8 | Register or pointer register (bit 0 cleared for pointers) |
| operand | output | 16 | Immediate value or index offset |
| aux_reg | output | 8 | Second source register (three-operand) or store data register |
| dst_reg | output | 8 | Destination register |
| wr_dst | output | 1 | Destination write is performed |
| post_inc | output | 1 | Indirect with post-increment |
| long_idx | output | 1 | Indexed with two-byte offset |
| length | output | 3 | Instruction length in bytes |
| is_jump | output | 1 | Relative jump decoded |
| jmp_target | output | 16 | Relative jump target |
| illegal | output | 1 | Undecodable encoding |

## Verification
A wrong modifier decode shows up in the cycle after the window is presented as a length that is off by one. That one error then misplaces `aux_reg` and `dst_reg`, and it flips `out_valid` for windows that are exactly one byte short or exactly the right size. A wrong sign extension appears only with negative short offsets or backward jumps, so both directions are driven. A wrong write-enable decision appears on `wr_dst` for stores and for register-0 destinations, in the same registered cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [1:0] {
        MD_REG = 2'b00,
        MD_IMM = 2'b01,
        MD_IND = 2'b10,
        MD_IDX = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        CL_ILL,
        CL_TRI,
        CL_DUO,
        CL_LD,
        CL_ST,
        CL_JMP
    } class_e;

    typedef struct packed {
        logic        valid;
        mode_e       mode;
        logic [7:0]  src_reg;
        logic [15:0] operand;
        logic [7:0]  aux_reg;
        logic [7:0]  dst_reg;
        logic        wr_dst;
        logic        post_inc;
        logic        long_idx;
        logic [2:0]  length;
        logic        is_jump;
        logic [15:0] jmp_target;
        logic        illegal;
    } dec_t;
endpackage

// File: rtl/mm_class_dec.sv
module mm_class_dec
    import mm_pkg::*;
(
    input  logic [7:0] opcode,
    output class_e     cls,
    output logic       byte_sz,
    output logic [1:0] reg_bytes
);
    always_comb begin
        byte_sz = opcode[4];
        case (opcode[7:5])
            3'b010:  cls = CL_TRI;
            3'b011:  cls = CL_DUO;
            3'b100:  cls = CL_LD;
            3'b101:  cls = (opcode[1:0] == MD_IMM) ? CL_ILL : CL_ST;
            3'b111:  cls = opcode[4] ? CL_ILL : CL_JMP;
            default: cls = CL_ILL;
        endcase
        case (cls)
            CL_TRI:                reg_bytes = 2'd2;
            CL_DUO, CL_LD, CL_ST:  reg_bytes = 2'd1;
            default:               reg_bytes = 2'd0;
        endcase
    end
endmodule

// File: rtl/mm_field_dec.sv
module mm_field_dec
    import mm_pkg::*;
(
    input  mode_e       mode,
    input  logic        byte_sz,
    input  logic [7:0]  b1,
    input  logic [7:0]  b2,
    input  logic [7:0]  b3,
    output logic [7:0]  src_reg,
    output logic [15:0] operand,
    output logic [1:0]  mm_len,
    output logic        post_inc,
    output logic        long_idx
);
    always_comb begin
        src_reg  = 8'h00;
        operand  = 16'h0000;
        mm_len   = 2'd1;
        post_inc = 1'b0;
        long_idx = 1'b0;
        case (mode)
            MD_REG: src_reg = b1;
            MD_IMM: begin
                if (byte_sz) begin
                    operand = {8'h00, b1};
                end else begin
                    operand = {b2, b1};
                    mm_len  = 2'd2;
                end
            end
            MD_IND: begin
                src_reg  = {b1[7:1], 1'b0};
                post_inc = b1[0];
            end
            default: begin
                src_reg  = {b1[7:1], 1'b0};
                long_idx = b1[0];
                if (b1[0]) begin
                    operand = {b3, b2};
                    mm_len  = 2'd3;
                end else begin
                    operand = {{8{b2[7]}}, b2};
                    mm_len  = 2'd2;
                end
            end
        endcase
    end
endmodule

// File: rtl/mm_operand_decoder.sv
module mm_operand_decoder
    import mm_pkg::*;
#(
    parameter int WIN_BYTES = 6,
    parameter int AW        = 16,
    localparam int WW = WIN_BYTES * 8,
    localparam int CW = $clog2(WIN_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] win,
    input  logic [CW-1:0] win_cnt,
    input  logic [AW-1:0] pc,
    output logic          out_valid,
    output logic [1:0]    mode,
    output logic [7:0]    src_reg,
    output logic [15:0]   operand,
    output logic [7:0]    aux_reg,
    output logic [7:0]    dst_reg,
    output logic          wr_dst,
    output logic          post_inc,
    output logic          long_idx,
    output logic [2:0]    length,
    output logic          is_jump,
    output logic [AW-1:0] jmp_target,
    output logic          illegal
);
    logic [7:0] bytes [WIN_BYTES];
    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_split
        assign bytes[g] = win[8*g +: 8];
    end

    class_e      cls;
    logic        byte_sz;
    logic [1:0]  reg_bytes;
    logic [7:0]  f_src;
    logic [15:0] f_opd;
    logic [1:0]  mm_len;
    logic        f_pinc, f_long;

    mm_class_dec u_cls (
        .opcode    (bytes[0]),
        .cls       (cls),
        .byte_sz   (byte_sz),
        .reg_bytes (reg_bytes)
    );

    mm_field_dec u_fld (
        .mode     (mode_e'(bytes[0][1:0])),
        .byte_sz  (byte_sz),
        .b1       (bytes[1]),
        .b2       (bytes[2]),
        .b3       (bytes[3]),
        .src_reg  (f_src),
        .operand  (f_opd),
        .mm_len   (mm_len),
        .post_inc (f_pinc),
        .long_idx (f_long)
    );

    dec_t dec_d, dec_q;
    logic [7:0]  tail0, tail1;
    logic [AW-1:0] tgt_d;

    always_comb begin
        tail0 = 8'h00;
        tail1 = 8'h00;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (i == 1 + int'(mm_len)) tail0 = bytes[i];
            if (i == 2 + int'(mm_len)) tail1 = bytes[i];
        end
        tgt_d = pc + AW'(2) + {{(AW-8){bytes[1][7]}}, bytes[1]};

        dec_d = '0;
        case (cls)
            CL_ILL: begin
                dec_d.illegal = 1'b1;
                dec_d.length  = 3'd1;
            end
            CL_JMP: begin
                dec_d.is_jump    = 1'b1;
                dec_d.length     = 3'd2;
                dec_d.jmp_target = 16'(tgt_d);
            end
            default: begin
                dec_d.mode     = mode_e'(bytes[0][1:0]);
                dec_d.src_reg  = f_src;
                dec_d.operand  = f_opd;
                dec_d.post_inc = f_pinc;
                dec_d.long_idx = f_long;
                dec_d.length   = 3'd1 + 3'(mm_len) + 3'(reg_bytes);
                if (cls == CL_TRI) begin
                    dec_d.aux_reg = tail0;
                    dec_d.dst_reg = tail1;
                end else if (cls == CL_ST) begin
                    dec_d.aux_reg = tail0;
                end else begin
                    dec_d.dst_reg = tail0;
                end
                dec_d.wr_dst = (cls != CL_ST) && (dec_d.dst_reg != 8'h00);
            end
        endcase
        dec_d.valid = (32'(win_cnt) >= 32'(dec_d.length));
        if (!dec_d.valid) dec_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid  = dec_q.valid;
    assign mode       = dec_q.mode;
    assign src_reg    = dec_q.src_reg;
    assign operand    = dec_q.operand;
    assign aux_reg    = dec_q.aux_reg;
    assign dst_reg    = dec_q.dst_reg;
    assign wr_dst     = dec_q.wr_dst;
    assign post_inc   = dec_q.post_inc;
    assign long_idx   = dec_q.long_idx;
    assign length     = dec_q.length;
    assign is_jump    = dec_q.is_jump;
    assign jmp_target = AW'(dec_q.jmp_target);
    assign illegal    = dec_q.illegal;

    AST_POSTINC_IND: assert property (@(posedge clk) disable iff (!rst_n)
        post_inc |-> (mode == MD_IND)); // R4
    AST_LONG_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        long_idx |-> (mode == MD_IDX && length >= 3'd5)); // R5
    AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode[1]) |-> !src_reg[0]); // R4
    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dst |-> (dst_reg != 8'h00)); // R9
    AST_ENOUGH_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (32'($past(win_cnt)) >= 32'(length))); // R11
    AST_ILLEGAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (length == 3'd1 && !wr_dst && !is_jump)); // R12
endmodule

// File: tb/mm_operand_decoder_tb.sv
module mm_operand_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] win = '0;
    logic [2:0]  win_cnt = '0;
    logic [15:0] pc = '0;
    logic        out_valid, wr_dst, post_inc, long_idx, is_jump, illegal;
    logic [1:0]  mode;
    logic [7:0]  src_reg, aux_reg, dst_reg;
    logic [15:0] operand, jmp_target;
    logic [2:0]  length;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mm_operand_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .win(win), .win_cnt(win_cnt), .pc(pc),
        .out_valid(out_valid), .mode(mode), .src_reg(src_reg), .operand(operand),
        .aux_reg(aux_reg), .dst_reg(dst_reg), .wr_dst(wr_dst), .post_inc(post_inc),
        .long_idx(long_idx), .length(length), .is_jump(is_jump),
        .jmp_target(jmp_target), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [47:0] w, input int cnt, input logic [15:0] p);
        @(negedge clk);
        win = w; win_cnt = 3'(cnt); pc = p;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 valid", {15'd0, out_valid}, 16'd0);
        chk("R13 len", {13'd0, length}, 16'd0);
        chk("R13 dst", {8'd0, dst_reg}, 16'd0);
    endtask

    task automatic t_direct();
        apply(48'h08_22_90, 3, 0);
        chk("R1 mode reg", {14'd0, mode}, 16'd0);
        chk("R2 src", {8'd0, src_reg}, 16'h0022);
        chk("R7 dst", {8'd0, dst_reg}, 16'h0008);
        chk("R6 len direct", {13'd0, length}, 16'd3);
        chk("R9 wr", {15'd0, wr_dst}, 16'd1);
    endtask

    task automatic t_immediate();
        apply(48'h08_A1_91, 3, 0);
        chk("R3 byte imm", operand, 16'h00A1);
        chk("R3 byte len", {13'd0, length}, 16'd3);
        apply(48'h08_12_34_81, 4, 0);
        chk("R3 word imm", operand, 16'h1234);
        chk("R3 word len", {13'd0, length}, 16'd4);
        chk("R7 word dst", {8'd0, dst_reg}, 16'h0008);
    endtask

    task automatic t_indirect();
        apply(48'h08_A1_92, 3, 0);
        chk("R4 pinc", {15'd0, post_inc}, 16'd1);
        chk("R4 ptr", {8'd0, src_reg}, 16'h00A0);
        chk("R6 len ind", {13'd0, length}, 16'd3);
        apply(48'h08_A0_92, 3, 0);
        chk("R4 no pinc", {15'd0, post_inc}, 16'd0);
    endtask

    task automatic t_indexed();
        apply(48'h08_53_A0_93, 4, 0);
        chk("R5 short off", operand, 16'h0053);
        chk("R5 short long", {15'd0, long_idx}, 16'd0);
        chk("R6 len short", {13'd0, length}, 16'd4);
        apply(48'h08_F0_A0_93, 4, 0);
        chk("R5 neg off", operand, 16'hFFF0);
        apply(48'h08_03_53_A1_93, 5, 0);
        chk("R5 long off", operand, 16'h0353);
        chk("R5 long flag", {15'd0, long_idx}, 16'd1);
        chk("R5 long ptr", {8'd0, src_reg}, 16'h00A0);
        chk("R6 len long", {13'd0, length}, 16'd5);
        chk("R7 long dst", {8'd0, dst_reg}, 16'h0008);
    endtask

    task automatic t_three();
        apply(48'h56_34_12_40, 4, 0);
        chk("R7 tri src", {8'd0, src_reg}, 16'h0012);
        chk("R7 tri aux", {8'd0, aux_reg}, 16'h0034);
        chk("R7 tri dst", {8'd0, dst_reg}, 16'h0056);
        apply(48'h56_34_80_00_6B_43, 6, 0);
        chk("R6 tri long len", {13'd0, length}, 16'd6);
        chk("R5 tri long off", operand, 16'h8000);
        chk("R7 tri long dst", {8'd0, dst_reg}, 16'h0056);
        chk("R7 tri long aux", {8'd0, aux_reg}, 16'h0034);
    endtask

    task automatic t_store();
        apply(48'h1C_40_B2, 3, 0);
        chk("R8 st aux", {8'd0, aux_reg}, 16'h001C);
        chk("R8 st dst", {8'd0, dst_reg}, 16'h0000);
        chk("R8 st wr", {15'd0, wr_dst}, 16'd0);
        chk("R8 st ptr", {8'd0, src_reg}, 16'h0040);
        apply(48'h1C_40_B1, 3, 0);
        chk("R8 st imm illegal", {15'd0, illegal}, 16'd1);
    endtask

    task automatic t_zero_dst();
        apply(48'h00_1F_6A_73, 4, 0);
        chk("R9 r0 valid", {15'd0, out_valid}, 16'd1);
        chk("R9 r0 wr", {15'd0, wr_dst}, 16'd0);
        chk("R9 r0 len", {13'd0, length}, 16'd4);
    endtask

    task automatic t_jump();
        apply(48'hFC_E5, 2, 16'h1000);
        chk("R10 back", jmp_target, 16'h0FFE);
        chk("R10 jmp flag", {15'd0, is_jump}, 16'd1);
        chk("R10 len", {13'd0, length}, 16'd2);
        apply(48'h10_E0, 2, 16'h2000);
        chk("R10 fwd", jmp_target, 16'h2012);
        apply(48'h01_E0, 2, 16'hFFFF);
        chk("R10 wrap", jmp_target, 16'h0002);
    endtask

    task automatic t_short_window();
        apply(48'h08_03_53_A1_93, 4, 0);
        chk("R11 short win valid", {15'd0, out_valid}, 16'd0);
        chk("R11 short win len", {13'd0, length}, 16'd0);
        apply(48'h08_03_53_A1_93, 5, 0);
        chk("R11 exact win", {15'd0, out_valid}, 16'd1);
        apply(48'h08_12_34_81, 3, 0);
        chk("R11 word imm short", {15'd0, out_valid}, 16'd0);
    endtask

    task automatic t_illegal();
        apply(48'h10, 1, 0);
        chk("R12 ill", {15'd0, illegal}, 16'd1);
        chk("R12 len", {13'd0, length}, 16'd1);
        apply(48'hF3, 1, 0);
        chk("R12 ill F", {15'd0, illegal}, 16'd1);
        apply(48'h08_22_90, 3, 0);
        chk("R1 legal", {15'd0, illegal}, 16'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_direct();
                t_immediate();
                t_indirect();
                t_indexed();
                t_three();
                t_store();
                t_zero_dst();
                t_jump();
                t_short_window();
                t_illegal();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule